// File: doc/BRIEF.md
# Comparator Edge Interrupt and Trigger Unit

This block takes the outputs of a set of free-running analog comparators, which change with no relation to the system clock. It brings each one into the clock domain and watches it for rising edges, falling edges or both, as chosen per channel. A detected edge latches a request bit that stays set until software clears it. The requests can be set by software, masked, and merged into a single interrupt line. A small register port lets software reach the request, set, mask, masked and live-level views.

Each channel also drives a trigger line for other hardware. By default the line gives a single one-clock pulse per qualifying edge. A level option turns it into a clocked copy of the comparator, and a bypass option routes the raw comparator input straight through with no clocking. Detection is gated by a global enable and a per-channel enable. The configuration inputs (enables, edge select, level and bypass bits) are static wires driven from elsewhere in the chip.

Top module: `cmp_edge_unit`

## Requirements
- R1: Each comparator input passes through a chain of SYNC_STAGES flip-flops (default 2). A change made before clock edge k is visible on the synchronized level after edge k+SYNC_STAGES-1 and not before.
- R2: Each channel's 2-bit edge select is encoded as 0 = no detection, 1 = rising edges, 2 = falling edges, 3 = both edges. A qualifying edge sets that channel's request bit (bit n for channel n) one clock after the edge shows on the synchronized level.
- R3: Edges are recorded only while both the global enable and the channel enable are 1. Otherwise no request is set and no trigger pulse is made.
- R4: With level select 0 and bypass 0, the trigger output emits a pulse exactly one clock long for each qualifying edge, in the same cycle the request bit rises.
- R5: With level select 1 and bypass 0, the trigger output equals the synchronized comparator level.
- R6: With bypass 1, the trigger output equals the raw comparator input, with no clock delay, whatever the level select.
- R7: Writing to address 0 clears each request bit written as 1. Bits written as 0 are unchanged. Reading address 0 returns the request bits.
- R8: Writing to address 1 sets each request bit written as 1. Bits written as 0 are unchanged. Address 1 reads as zero.
- R9: If a hardware edge or a software set hits a request bit in the same cycle as a clear of that bit, the bit ends up set.
- R10: Address 2 is the read-write mask. Address 3 reads the bitwise AND of request and mask. The irq output is 1 exactly when any masked bit is 1.
- R11: Address 4 reads the synchronized comparator levels, one bit per channel. Other addresses read as zero.
- R12: After reset, all request and mask bits, irq and the pulse-mode trigger outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global detection enable |
| ch_en | input | NUM_CH | Per-channel detection enable |
| edge_sel | input | 2*NUM_CH | Edge select, channel n at bits 2n+1:2n |
| lvl_mode | input | NUM_CH | 1 = trigger is a level, 0 = pulse |
| sync_bypass | input | NUM_CH | 1 = trigger is the raw comparator input |
| cmp_async | input | NUM_CH | Asynchronous comparator outputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NUM_CH | Register write data |
| reg_rdata | output | NUM_CH | Register read data (combinational) |
| trig_out | output | NUM_CH | Per-channel trigger output |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with its defaults: two channels and a two-stage synchronizer. With two channels, one channel can sit idle with detection off while the other is driven, so any leak between channel bits in the request, mask and status views shows up. The two-stage depth fixes the edge on which the level, the request and the pulse appear, so the bench can check the exact cycle. A hardware edge can also be timed to land on the same edge as a clear write.

// File: rtl/cmp_edge_pkg.sv
package cmp_edge_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_BOTH = 2'd3
   } edge_sel_e;

   localparam int REG_AW = 3;
   localparam logic [REG_AW-1:0] ADDR_REQ    = 3'd0;
   localparam logic [REG_AW-1:0] ADDR_SET    = 3'd1;
   localparam logic [REG_AW-1:0] ADDR_MASK   = 3'd2;
   localparam logic [REG_AW-1:0] ADDR_MASKED = 3'd3;
   localparam logic [REG_AW-1:0] ADDR_LEVEL  = 3'd4;
endpackage

// File: rtl/cmp_edge_sync.sv
module cmp_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_depth
      $error("cmp_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_chan.sv
module cmp_edge_chan
   import cmp_edge_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmp_raw,
   input  logic       det_en,
   input  logic [1:0] esel,
   input  logic       lvl_mode,
   input  logic       bypass,
   output logic       lvl_sync,
   output logic       edge_hit,
   output logic       trig
);
   logic lvl_prev_q;
   logic pulse_q;
   logic rise_w, fall_w;
   edge_sel_e sel_w;

   cmp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (cmp_raw),
      .q_sync  (lvl_sync)
   );

   assign sel_w  = edge_sel_e'(esel);
   assign rise_w = lvl_sync & ~lvl_prev_q;
   assign fall_w = ~lvl_sync & lvl_prev_q;

   always_comb begin
      unique case (sel_w)
         EDGE_RISE: edge_hit = det_en & rise_w;
         EDGE_FALL: edge_hit = det_en & fall_w;
         EDGE_BOTH: edge_hit = det_en & (rise_w | fall_w);
         default:   edge_hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev_q <= 1'b0;
         pulse_q    <= 1'b0;
      end else begin
         lvl_prev_q <= lvl_sync;
         pulse_q    <= edge_hit;
      end
   end

   assign trig = bypass ? cmp_raw : (lvl_mode ? lvl_sync : pulse_q);

   // R4
   pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_q && esel == EDGE_RISE && $past(esel) == EDGE_RISE) |=> !pulse_q);

   // R3
   gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !det_en |=> !pulse_q);
endmodule

// File: rtl/cmp_edge_regs.sv
module cmp_edge_regs
   import cmp_edge_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] addr,
   input  logic [NUM_CH-1:0] wdata,
   input  logic [NUM_CH-1:0] hw_set,
   input  logic [NUM_CH-1:0] lvl,
   output logic [NUM_CH-1:0] rdata,
   output logic              irq
);
   logic [NUM_CH-1:0] req_q, mask_q;
   logic [NUM_CH-1:0] clr_v, set_v, masked_w;

   assign clr_v = (we && addr == ADDR_REQ) ? wdata : '0;
   assign set_v = (we && addr == ADDR_SET) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         mask_q <= '0;
      end else begin
         req_q <= (req_q & ~clr_v) | hw_set | set_v;
         if (we && addr == ADDR_MASK) mask_q <= wdata;
      end
   end

   assign masked_w = req_q & mask_q;
   assign irq      = |masked_w;

   always_comb begin
      unique case (addr)
         ADDR_REQ:    rdata = req_q;
         ADDR_MASK:   rdata = mask_q;
         ADDR_MASKED: rdata = masked_w;
         ADDR_LEVEL:  rdata = lvl;
         default:     rdata = '0;
      endcase
   end

   for (genvar b = 0; b < NUM_CH; b++) begin : g_chk
      // R2
      req_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(req_q[b]) |-> $past(hw_set[b] | set_v[b]));
      // R7
      w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_v[b] && !hw_set[b] && !set_v[b]) |=> !req_q[b]);
      // R9
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_v[b] && hw_set[b]) |=> req_q[b]);
   end
endmodule

// File: rtl/cmp_edge_unit.sv
module cmp_edge_unit
   import cmp_edge_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                glb_en,
   input  logic [NUM_CH-1:0]   ch_en,
   input  logic [2*NUM_CH-1:0] edge_sel,
   input  logic [NUM_CH-1:0]   lvl_mode,
   input  logic [NUM_CH-1:0]   sync_bypass,
   input  logic [NUM_CH-1:0]   cmp_async,
   input  logic                reg_we,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [NUM_CH-1:0]   reg_wdata,
   output logic [NUM_CH-1:0]   reg_rdata,
   output logic [NUM_CH-1:0]   trig_out,
   output logic                irq
);
   localparam int SEL_W = 2;

   logic [NUM_CH-1:0] lvl_w, hit_w;

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
      $error("cmp_edge_unit: NUM_CH must be 1..32");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      cmp_edge_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .cmp_raw  (cmp_async[c]),
         .det_en   (glb_en & ch_en[c]),
         .esel     (edge_sel[c*SEL_W +: SEL_W]),
         .lvl_mode (lvl_mode[c]),
         .bypass   (sync_bypass[c]),
         .lvl_sync (lvl_w[c]),
         .edge_hit (hit_w[c]),
         .trig     (trig_out[c])
      );
   end

   cmp_edge_regs #(.NUM_CH(NUM_CH)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .hw_set (hit_w),
      .lvl    (lvl_w),
      .rdata  (reg_rdata),
      .irq    (irq)
   );
endmodule

// File: tb/cmp_edge_unit_tb.sv
`timescale 1ns/1ps
module cmp_edge_unit_tb_top;
   localparam int N = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         glb_en = 1'b0;
   logic [N-1:0] ch_en = '0;
   logic [2*N-1:0] edge_sel = '0;
   logic [N-1:0] lvl_mode = '0;
   logic [N-1:0] sync_bypass = '0;
   logic [N-1:0] cmp_async = '0;
   logic         reg_we = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic [N-1:0] reg_wdata = '0;
   logic [N-1:0] reg_rdata;
   logic [N-1:0] trig_out;
   logic         irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cmp_edge_unit #(.NUM_CH(N), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .ch_en(ch_en),
      .edge_sel(edge_sel), .lvl_mode(lvl_mode), .sync_bypass(sync_bypass),
      .cmp_async(cmp_async), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_out(trig_out), .irq(irq)
   );

   // {edge select, start level, end level, expected request/pulse count}
   localparam logic [4:0] VEC [8] = '{
      {2'd0, 1'b0, 1'b1, 1'b0},
      {2'd1, 1'b0, 1'b1, 1'b1},
      {2'd1, 1'b1, 1'b0, 1'b0},
      {2'd2, 1'b0, 1'b1, 1'b0},
      {2'd2, 1'b1, 1'b0, 1'b1},
      {2'd3, 1'b0, 1'b1, 1'b1},
      {2'd3, 1'b1, 1'b0, 1'b1},
      {2'd0, 1'b1, 1'b0, 1'b0}
   };

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] rv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), rv);
         check("R12 reg after reset", int'(rv), 0);
      end
      check("R12 irq after reset", int'(irq), 0);
      check("R12 trig after reset", int'(trig_out), 0);

      // R2 R4 vector table on channel 0, channel 1 idle
      glb_en = 1'b1; ch_en = 2'b11;
      for (int v = 0; v < 8; v++) begin
         int cnt;
         edge_sel = {2'd0, VEC[v][4:3]};
         cmp_async[0] = VEC[v][2];
         repeat (4) @(negedge clk);
         wr(3'd0, 2'b11);
         cmp_async[0] = VEC[v][1];
         cnt = 0;
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (trig_out[0]) cnt++;
         end
         rd(3'd0, rv);
         check("R2 request after edge", int'(rv), int'(VEC[v][0]));
         check("R4 pulse count", cnt, int'(VEC[v][0]));
      end

      // R4 pulse exact cycle
      edge_sel = 4'b0001; cmp_async = '0;
      repeat (4) @(negedge clk);
      wr(3'd0, 2'b11);
      cmp_async[0] = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R4 no pulse before edge+2", int'(trig_out[0]), 0);
      @(negedge clk);
      check("R4 pulse on edge+2", int'(trig_out[0]), 1);
      @(negedge clk);
      check("R4 pulse ends", int'(trig_out[0]), 0);

      // R3 disabled
      cmp_async = '0; repeat (4) @(negedge clk);
      wr(3'd0, 2'b11);
      glb_en = 1'b0;
      cmp_async[0] = 1'b1;
      repeat (4) @(negedge clk);
      rd(3'd0, rv);
      check("R3 global off no request", int'(rv), 0);
      glb_en = 1'b1; ch_en = 2'b10;
      cmp_async[0] = 1'b0; repeat (4) @(negedge clk);
      cmp_async[0] = 1'b1; repeat (4) @(negedge clk);
      rd(3'd0, rv);
      check("R3 channel off no request", int'(rv), 0);
      ch_en = 2'b11;

      // R1 R5 R11 level mode and status
      edge_sel = '0; lvl_mode = 2'b01; cmp_async = '0;
      repeat (4) @(negedge clk);
      reg_addr = 3'd4;
      cmp_async[0] = 1'b1;
      @(negedge clk);
      check("R1 level not yet", int'(trig_out[0]), 0);
      @(negedge clk);
      check("R5 level synced copy", int'(trig_out[0]), 1);
      rd(3'd4, rv);
      check("R11 status level", int'(rv), 1);
      cmp_async[1] = 1'b1; repeat (3) @(negedge clk);
      rd(3'd4, rv);
      check("R11 status both", int'(rv), 3);

      // R6 bypass
      sync_bypass = 2'b11; lvl_mode = 2'b00;
      cmp_async = 2'b10; #0.5;
      check("R6 bypass raw", int'(trig_out), 2);
      cmp_async = 2'b01; #0.5;
      check("R6 bypass follows", int'(trig_out), 1);
      sync_bypass = '0; cmp_async = '0;
      repeat (4) @(negedge clk);

      // R8 R7 R10 software set, clear, mask
      wr(3'd0, 2'b11);
      wr(3'd1, 2'b10);
      rd(3'd0, rv);
      check("R8 set writes one", int'(rv), 2);
      rd(3'd1, rv);
      check("R8 set address reads zero", int'(rv), 0);
      wr(3'd1, 2'b00);
      rd(3'd0, rv);
      check("R8 set zero no effect", int'(rv), 2);
      check("R10 irq masked off", int'(irq), 0);
      wr(3'd2, 2'b10);
      rd(3'd3, rv);
      check("R10 masked view", int'(rv), 2);
      check("R10 irq on", int'(irq), 1);
      wr(3'd2, 2'b01);
      rd(3'd3, rv);
      check("R10 masked view other bit", int'(rv), 0);
      check("R10 irq off", int'(irq), 0);
      rd(3'd2, rv);
      check("R10 mask readback", int'(rv), 1);
      wr(3'd0, 2'b00);
      rd(3'd0, rv);
      check("R7 clear zero no effect", int'(rv), 2);
      wr(3'd0, 2'b10);
      rd(3'd0, rv);
      check("R7 clear one", int'(rv), 0);
      rd(3'd6, rv);
      check("R11 unused address", int'(rv), 0);

      // R9 hardware edge same cycle as clear
      edge_sel = 4'b0001; cmp_async = '0;
      repeat (4) @(negedge clk);
      cmp_async[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr(3'd0, 2'b01);
      rd(3'd0, rv);
      check("R9 set beats clear", int'(rv), 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule